// File: doc/BRIEF.md
# Toggle Poll Controller

This block runs on the host side of a flash-like memory after a program or erase has been started. It judges whether the operation has finished by reading the device status word in pairs and comparing one toggling status bit between the two reads. A stable bit means the operation is complete. A bit that keeps flipping means the operation is still running, unless the timeout status bit is also set. In that case the block reads one more pair to confirm the result. If the bit is still flipping after the timeout flag was seen, the block writes the reset command to the device and reports failure.

Reads use a request/acknowledge pair: the block holds `rdReq` high, and every cycle with `rdAck` high completes one read, with `rdData` valid in that cycle. While the operation is still running and no timeout is flagged, the host chooses between two actions with `keepPolling`: start a fresh read pair, or leave with an abandoned result. A later `start` always begins again from a new first read. A poll limit forces an abandoned result after a set number of toggling pairs. Each result is a one-cycle pulse, and `busy` covers the whole polling run.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: Each check reads two status words in a row, and the toggle bit of the first read is stored for comparison with the second. `rdReq` stays high until a cycle with `rdAck` high, and each such cycle completes one read with `rdData` valid in it.
- R2: If the toggle bit is equal in both reads of a pair, `done` pulses. The other bits of the word do not affect this, including the timeout bit (bit TIMEOUT_BIT, default 5).
- R3: If the toggle bit differs and the timeout bit of the second read is 0, the block does one of two things. With `keepPolling`=1 it starts a new read pair. With `keepPolling`=0 it pulses `abandoned` after that pair, with no command write.
- R4: If the toggle bit differs and the timeout bit of the second read is 1, one more pair is read. If the toggle bit is equal in that pair, `done` pulses and no command is written.
- R5: If the toggle bit still differs in the confirming pair, the block holds `cmdWrReq` high with `cmdWrData`=RESET_CMD (default 8'hF0) until `cmdWrAck`. `fail` pulses in the cycle after the acknowledge.
- R6: `start` is accepted only while idle. Each accepted start begins with a new first read, clears the poll count and clears any pending confirmation. A `start` while busy has no effect.
- R7: `done`, `fail` and `abandoned` are single-cycle pulses, and at most one is high at a time. `busy` is high from the cycle after an accepted start and is low in the cycle the result pulse is high.
- R8: The toggle bit position is the parameter TOGGLE_BIT, intended to be 6 or 2 (default 6). A change in any other bit of the status word between the two reads is not treated as toggling.
- R9: After MAX_POLLS consecutive pairs that toggle with the timeout bit low, `abandoned` pulses even when `keepPolling`=1.
- R10: During and right after reset, `busy`, `rdReq`, `cmdWrReq`, `done`, `fail` and `abandoned` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a polling run (only while idle) |
| keepPolling | input | 1 | 1: keep polling while toggling without timeout; 0: abandon |
| rdReq | output | 1 | Status read request |
| rdAck | input | 1 | Read acknowledge; `rdData` valid in this cycle |
| rdData | input | DATA_W | Status word returned by the memory |
| cmdWrReq | output | 1 | Command write request (reset command) |
| cmdWrAck | input | 1 | Command write acknowledge |
| cmdWrData | output | DATA_W | Command value, the reset command |
| busy | output | 1 | Polling run in progress |
| done | output | 1 | Pulse: operation completed |
| fail | output | 1 | Pulse: operation failed, reset command written |
| abandoned | output | 1 | Pulse: polling left without a verdict |

## Verification
The timeout flag rising and the toggle bit stopping can arrive in the same read. When they do, the stopped bit must win and the result is success. The bench provokes this with a pair whose second word has the timeout bit set and the toggle bit equal to the first word. It expects `done` after exactly two reads with no command write. It then checks the same case inside the confirming pair, and a contrasting pair where the bit still flips, which must end in the reset write and `fail`.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2,
    ST_RST  = 2'd3
  } tpState_t;

  typedef struct packed {
    logic clrAll;
    logic capFirst;
    logic incPoll;
    logic setRecheck;
  } tpStrobe_t;
endpackage

// File: rtl/tpoll_datapath.sv
module tpoll_datapath
  import tpoll_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TOGGLE_BIT  = 6,
  parameter int TIMEOUT_BIT = 5,
  parameter int MAX_POLLS   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tpStrobe_t         str,
  input  logic [DATA_W-1:0] rdData,
  output logic              toggled,
  output logic              timeoutHi,
  output logic              limitHit,
  output logic              recheck
);
  localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_POLLS - 1);

  logic             firstBit;
  logic [CNT_W-1:0] pollCnt;
  logic             unusedData;

  assign unusedData = ^rdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstBit <= 1'b0;
      pollCnt  <= '0;
      recheck  <= 1'b0;
    end else begin
      if (str.capFirst) firstBit <= rdData[TOGGLE_BIT];
      if (str.clrAll) begin
        pollCnt <= '0;
        recheck <= 1'b0;
      end else begin
        if (str.incPoll)    pollCnt <= pollCnt + 1'b1;
        if (str.setRecheck) recheck <= 1'b1;
      end
    end
  end

  // Compared against the second read of a pair
  assign toggled   = rdData[TOGGLE_BIT] != firstBit;
  assign timeoutHi = rdData[TIMEOUT_BIT];
  assign limitHit  = pollCnt == CNT_LAST;

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    str.clrAll |=> (pollCnt == '0) && !recheck);

  a_r9_no_inc_at_limit: assert property (@(posedge clk) disable iff (!rstN)
    str.incPoll |-> !limitHit);
endmodule

// File: rtl/tpoll_ctrl.sv
module tpoll_ctrl
  import tpoll_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      keepPolling,
  input  logic      rdAck,
  input  logic      cmdWrAck,
  input  logic      toggled,
  input  logic      timeoutHi,
  input  logic      limitHit,
  input  logic      recheck,
  output tpStrobe_t str,
  output logic      rdReq,
  output logic      cmdWrReq,
  output logic      busy,
  output logic      done,
  output logic      fail,
  output logic      abandoned
);
  tpState_t state, nextState;
  logic doneNx, failNx, abandonNx;

  always_comb begin
    nextState = state;
    str       = '0;
    doneNx    = 1'b0;
    failNx    = 1'b0;
    abandonNx = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        str.clrAll = 1'b1;
        nextState  = ST_RD1;
      end
      ST_RD1: if (rdAck) begin
        str.capFirst = 1'b1;
        nextState    = ST_RD2;
      end
      ST_RD2: if (rdAck) begin
        if (!toggled) begin
          doneNx    = 1'b1;
          nextState = ST_IDLE;
        end else if (recheck) begin
          nextState = ST_RST;
        end else if (timeoutHi) begin
          str.setRecheck = 1'b1;
          nextState      = ST_RD1;
        end else if (limitHit || !keepPolling) begin
          abandonNx = 1'b1;
          nextState = ST_IDLE;
        end else begin
          str.incPoll = 1'b1;
          nextState   = ST_RD1;
        end
      end
      ST_RST: if (cmdWrAck) begin
        failNx    = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      fail      <= 1'b0;
      abandoned <= 1'b0;
    end else begin
      state     <= nextState;
      done      <= doneNx;
      fail      <= failNx;
      abandoned <= abandonNx;
    end
  end

  assign rdReq    = (state == ST_RD1) || (state == ST_RD2);
  assign cmdWrReq = state == ST_RST;
  assign busy     = state != ST_IDLE;

  a_r1_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> rdReq);

  a_r5_fail_after_write: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> $past(cmdWrReq && cmdWrAck));

  a_r7_one_result: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, fail, abandoned}));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_fail_pulse: assert property (@(posedge clk) disable iff (!rstN)
    fail |=> !fail);

  a_r7_idle_at_result: assert property (@(posedge clk) disable iff (!rstN)
    (done || fail || abandoned) |-> !busy);
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import tpoll_pkg::*;
#(
  parameter int               DATA_W      = 8,
  parameter int               TOGGLE_BIT  = 6,
  parameter int               TIMEOUT_BIT = 5,
  parameter int               MAX_POLLS   = 16,
  parameter logic [DATA_W-1:0] RESET_CMD  = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              keepPolling,
  output logic              rdReq,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  output logic              cmdWrReq,
  input  logic              cmdWrAck,
  output logic [DATA_W-1:0] cmdWrData,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              abandoned
);
  tpStrobe_t str;
  logic toggled, timeoutHi, limitHit, recheck;

  assign cmdWrData = RESET_CMD;

  tpoll_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .keepPolling(keepPolling),
    .rdAck(rdAck), .cmdWrAck(cmdWrAck), .toggled(toggled),
    .timeoutHi(timeoutHi), .limitHit(limitHit), .recheck(recheck),
    .str(str), .rdReq(rdReq), .cmdWrReq(cmdWrReq), .busy(busy),
    .done(done), .fail(fail), .abandoned(abandoned)
  );

  tpoll_datapath #(
    .DATA_W(DATA_W), .TOGGLE_BIT(TOGGLE_BIT),
    .TIMEOUT_BIT(TIMEOUT_BIT), .MAX_POLLS(MAX_POLLS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .str(str), .rdData(rdData),
    .toggled(toggled), .timeoutHi(timeoutHi),
    .limitHit(limitHit), .recheck(recheck)
  );
endmodule

// File: tb/test_toggle_poll_ctrl.sv
module test_toggle_poll_ctrl;
  typedef struct packed {
    logic [63:0] seq;     // first read in bits [7:0]
    logic        keep;
    logic [1:0]  kind;    // 0 done, 1 fail, 2 abandoned
    logic [3:0]  reads;
    logic [1:0]  writes;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{64'h4040,              1'b1, 2'd0, 4'd2, 2'd0}, // R2 stable high
    '{64'h8F00,              1'b1, 2'd0, 4'd2, 2'd0}, // R8 other bits change
    '{64'h40400040,          1'b1, 2'd0, 4'd4, 2'd0}, // R3 keep polling
    '{64'h0040,              1'b0, 2'd2, 4'd2, 2'd0}, // R3 abandon
    '{64'h0000,              1'b1, 2'd0, 4'd2, 2'd0}, // R6 resume fresh
    '{64'h6040,              1'b1, 2'd0, 4'd2, 2'd0}, // R2 timeout and stop together
    '{64'h00002040,          1'b1, 2'd0, 4'd4, 2'd0}, // R4 confirm stopped
    '{64'h40002040,          1'b1, 2'd1, 4'd4, 2'd1}, // R5 confirm still toggling
    '{64'h00406000,          1'b1, 2'd1, 4'd4, 2'd1}, // R5 second pattern
    '{64'h004000400040,      1'b1, 2'd2, 4'd6, 2'd0}  // R9 limit of 3
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic keepPolling = 1'b1;
  logic rdReq, rdAck = 1'b0;
  logic [7:0] rdData = 8'h00;
  logic cmdWrReq, cmdWrAck = 1'b0;
  logic [7:0] cmdWrData;
  logic busy, done, fail, abandoned;

  logic [7:0] seqMem [8];
  int rdCount = 0;
  int wrCount = 0;
  logic [7:0] lastCmd = 8'h00;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  toggle_poll_ctrl #(.MAX_POLLS(3)) i_toggle_poll_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .keepPolling(keepPolling),
    .rdReq(rdReq), .rdAck(rdAck), .rdData(rdData),
    .cmdWrReq(cmdWrReq), .cmdWrAck(cmdWrAck), .cmdWrData(cmdWrData),
    .busy(busy), .done(done), .fail(fail), .abandoned(abandoned)
  );

  // Memory responder: one acknowledge cycle per request, away from the edge
  initial begin
    forever begin
      @(negedge clk);
      if (rdAck) rdAck = 1'b0;
      else if (rdReq) begin
        rdAck  = 1'b1;
        rdData = seqMem[rdCount % 8];
        rdCount++;
      end
      if (cmdWrAck) cmdWrAck = 1'b0;
      else if (cmdWrReq) begin
        cmdWrAck = 1'b1;
        lastCmd  = cmdWrData;
        wrCount++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic loadSeq(input logic [63:0] s);
    for (int i = 0; i < 8; i++) seqMem[i] = s[8*i +: 8];
    rdCount = 0;
    wrCount = 0;
  endtask

  task automatic waitResult(output int kind);
    kind = 3;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done || fail || abandoned) begin
        kind = done ? 0 : (fail ? 1 : 2);
        break;
      end
    end
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int kind;
    loadSeq(v.seq);
    keepPolling = v.keep;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, $sformatf("R7 busy after start v%0d", idx), busy, 1);
    waitResult(kind);
    check(kind == int'(v.kind), $sformatf("R2/R3/R4/R5/R9 result v%0d", idx), kind, v.kind);
    check(busy == 1'b0, $sformatf("R7 busy low at result v%0d", idx), busy, 0);
    check(rdCount == int'(v.reads), $sformatf("R1 read count v%0d", idx), rdCount, v.reads);
    check(wrCount == int'(v.writes), $sformatf("R5 write count v%0d", idx), wrCount, v.writes);
    if (v.writes != 0)
      check(lastCmd == 8'hF0, $sformatf("R5 reset command v%0d", idx), lastCmd, 8'hF0);
    @(negedge clk);
    check({done, fail, abandoned} == 3'b000, $sformatf("R7 single pulse v%0d", idx),
          {done, fail, abandoned}, 0);
  endtask

  initial begin
    int kind;
    for (int i = 0; i < 8; i++) seqMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    check({busy, rdReq, cmdWrReq, done, fail, abandoned} == 6'b0, "R10 in reset",
          {busy, rdReq, cmdWrReq, done, fail, abandoned}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, rdReq, cmdWrReq, done, fail, abandoned} == 6'b0, "R10 after reset",
          {busy, rdReq, cmdWrReq, done, fail, abandoned}, 0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], i);

    // R6 start while busy is ignored
    loadSeq(64'h40400040);
    keepPolling = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 50 && rdCount < 2; i++) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitResult(kind);
    check(kind == 0, "R6 start while busy result", kind, 0);
    check(rdCount == 4, "R6 start while busy reads", rdCount, 4);
    @(negedge clk);
    check(busy == 1'b0, "R6 idle after run", busy, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule